// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a multi-channel event timer. The channel compares a free-running main counter, shared by all channels and supplied from outside, against its own 64-bit comparator. When the two are equal on a counter tick, the channel emits a one-clock interrupt pulse together with the number of the interrupt line it is routed to. Software programs the channel through a small 32-bit register window of four words. The words are configuration, route capability, comparator low half and comparator high half.

The channel runs either one-shot or periodic. In periodic mode, a hidden reload period is added to the comparator on every match. While the channel is periodic, comparator writes load that period instead of the comparator, unless a self-clearing "set value" bit has been set in the configuration. A force-32-bit mode narrows the comparator, the period and the compare itself to 32 bits. A global legacy flag overrides the route of channels 0 and 1.

Top module: `evt_chan`

## Requirements
- R1: After reset, the configuration word reads 0x00000030 (bit 4 periodic-capable and bit 5 64-bit-capable are both 1). Both comparator halves read 0xFFFFFFFF, and irq_o is low.
- R2: A write to word 0 (configuration) changes only the bits under mask 0x3F4E: bit 1 level, bit 2 enable, bit 3 periodic, bit 6 set-value, bit 8 force-32 and bits 13:9 route. All other bits keep their value, and bits 4 and 5 always read 1.
- R3: Word 1 always reads the route capability 0x000000FF, and writes to it are ignored.
- R4: A write to word 2 loads the low half and a write to word 3 loads the high half of the target. The target is the comparator when bit 3 is 0 or bit 6 is 1, and the hidden period otherwise. Bit 6 reads 0 after any write to word 2 or word 3.
- R5: While bit 8 is 1, the comparator and the period have a zero upper half. A configuration write with bit 8 set clears the upper halves of both, and later writes to the high half leave it zero.
- R6: A match occurs on a cycle with tick_i high and glb_en_i high when count_i equals the comparator (only the low 32 bits are compared when bit 8 is 1). irq_o is high for exactly the one cycle after a matching tick with bit 2 set.
- R7: On a match with bit 3 set, the comparator becomes comparator plus period (wrapped to 32 bits when bit 8 is 1). This holds whether bit 2 is set or not.
- R8: No pulse is produced when glb_en_i is low or when bit 2 is clear.
- R9: When legacy_i is high, channel 0 drives route_o = 0 and channel 1 drives route_o = 8. All other channels, and every channel while legacy_i is low, drive route_o from bits 13:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Main counter holds a new value this cycle |
| count_i | input | CW | Main counter value |
| glb_en_i | input | 1 | Global timer enable |
| legacy_i | input | 1 | Legacy route override |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word index in the channel window (0 cfg, 1 cap, 2 cmp low, 3 cmp high) |
| wdata_i | input | CW/2 | Write data |
| rd_data_o | output | CW/2 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt pulse, one clock |
| route_o | output | 5 | Interrupt line number for the pulse |

## Verification
The one-clock pulse property assumes that the main counter presents a different value on consecutive ticks. It also assumes that the period is never zero while the counter stalls on the comparator value. The stimulus gives every tick its own count and programs only non-zero periods. The set-value check assumes a write strobe is never held through reset. Random register traffic runs with the global enable low, so the reference model of the comparator changes only through writes during that phase.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  localparam int B_LVL  = 1;
  localparam int B_EN   = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_WCAP = 5;
  localparam int B_SETV = 6;
  localparam int B_M32  = 8;
  localparam int RT_LO  = 9;
  localparam int RT_W   = 5;
  localparam logic [31:0] CFG_WMASK = 32'h0000_3F4E;
  localparam logic [31:0] CFG_RST   = 32'h0000_0030;
  localparam logic [1:0] OFS_CFG = 2'd0;
  localparam logic [1:0] OFS_CAP = 2'd1;
  localparam logic [1:0] OFS_CLO = 2'd2;
  localparam logic [1:0] OFS_CHI = 2'd3;
endpackage

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_chan_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [CW/2-1:0]   wdata_i,
  input  logic              adv_i,
  output logic [31:0]       cfg_o,
  output logic [CW-1:0]     cmp_o
);
  localparam int HW = CW / 2;

  logic [31:0]   cfg_q;
  logic [CW-1:0] cmp_q, per_q, nv, sum;
  logic          wr_cfg, wr_cmp, ld_cmp, m32;

  assign m32    = cfg_q[B_M32];
  assign wr_cfg = wr_en_i && (addr_i == OFS_CFG);
  assign wr_cmp = wr_en_i && (addr_i == OFS_CLO || addr_i == OFS_CHI);
  assign ld_cmp = !cfg_q[B_PER] || cfg_q[B_SETV];

  always_comb begin
    nv = ld_cmp ? cmp_q : per_q;
    if (addr_i == OFS_CHI) nv[CW-1:HW] = wdata_i;
    else                   nv[HW-1:0]  = wdata_i;
    if (m32) nv[CW-1:HW] = '0;
    sum = cmp_q + per_q;
    if (m32) sum[CW-1:HW] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= (32'(wdata_i) & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
      if (wdata_i[B_M32]) begin
        cmp_q[CW-1:HW] <= '0;
        per_q[CW-1:HW] <= '0;
      end
    end else if (wr_cmp) begin
      if (ld_cmp) cmp_q <= nv;
      else        per_q <= nv;
      cfg_q[B_SETV] <= 1'b0;
    end else if (adv_i) begin
      cmp_q <= sum;
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/evt_chan_match.sv
module evt_chan_match #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          m32_i,
  input  logic          glb_en_i,
  input  logic          chan_en_i,
  input  logic          periodic_i,
  output logic          adv_o,
  output logic          irq_o
);
  localparam int HW = CW / 2;

  logic eq_lo, eq_hi, hit, irq_q;

  assign eq_lo = count_i[HW-1:0] == cmp_i[HW-1:0];
  assign eq_hi = count_i[CW-1:HW] == cmp_i[CW-1:HW];
  assign hit   = tick_i && glb_en_i && eq_lo && (eq_hi || m32_i);
  assign adv_o = hit && periodic_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hit && chan_en_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_chan_route.sv
module evt_chan_route
  import evt_chan_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic            legacy_i,
  input  logic [RT_W-1:0] field_i,
  output logic [RT_W-1:0] route_o
);
  generate
    if (CHAN_IDX == 0) begin : g_leg0
      assign route_o = legacy_i ? RT_W'(0) : field_i;
    end else if (CHAN_IDX == 1) begin : g_leg1
      assign route_o = legacy_i ? RT_W'(8) : field_i;
    end else begin : g_plain
      logic unused_leg;
      assign unused_leg = legacy_i;
      assign route_o = field_i;
    end
  endgenerate
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_chan_pkg::*;
#(
  parameter int          CHAN_IDX  = 0,
  parameter int          CW        = 64,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_00FF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [CW-1:0]   count_i,
  input  logic            glb_en_i,
  input  logic            legacy_i,
  input  logic            wr_en_i,
  input  logic [1:0]      addr_i,
  input  logic [CW/2-1:0] wdata_i,
  output logic [CW/2-1:0] rd_data_o,
  output logic            irq_o,
  output logic [4:0]      route_o
);
  localparam int HW = CW / 2;

  logic [31:0]   cfg_w;
  logic [CW-1:0] cmp_w;
  logic          adv_w;

  evt_chan_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .adv_i(adv_w), .cfg_o(cfg_w), .cmp_o(cmp_w)
  );

  evt_chan_match #(.CW(CW)) u_match (
    .clk_i, .rst_ni, .tick_i, .count_i,
    .cmp_i(cmp_w), .m32_i(cfg_w[B_M32]), .glb_en_i,
    .chan_en_i(cfg_w[B_EN]), .periodic_i(cfg_w[B_PER]),
    .adv_o(adv_w), .irq_o
  );

  evt_chan_route #(.CHAN_IDX(CHAN_IDX)) u_route (
    .legacy_i, .field_i(cfg_w[RT_LO +: RT_W]), .route_o
  );

  always_comb begin
    unique case (addr_i)
      OFS_CFG: rd_data_o = HW'(cfg_w);
      OFS_CAP: rd_data_o = HW'(ROUTE_CAP);
      OFS_CLO: rd_data_o = cmp_w[HW-1:0];
      default: rd_data_o = cmp_w[CW-1:HW];
    endcase
  end
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk
  import evt_chan_pkg::*;
#(
  parameter int          CHAN_IDX  = 0,
  parameter int          CW        = 64,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_00FF
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            glb_en_i,
  input logic            legacy_i,
  input logic            wr_en_i,
  input logic [1:0]      addr_i,
  input logic [CW/2-1:0] rd_data_o,
  input logic            irq_o,
  input logic [4:0]      route_o,
  input logic [31:0]     cfg_q,
  input logic [CW-1:0]   cmp_q
);
  localparam int HW = CW / 2;

  a_r8_pulse_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(glb_en_i) && $past(tick_i) && $past(cfg_q[B_EN])));

  a_r6_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[B_M32] |-> (cmp_q[CW-1:HW] == '0));

  a_r3_cap_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CAP) |-> (rd_data_o == HW'(ROUTE_CAP)));

  a_r2_cap_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CFG) |-> (rd_data_o[B_WCAP:B_PCAP] == 2'b11));

  a_r4_setval_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1]) |=> !cfg_q[B_SETV]);

  generate
    if (CHAN_IDX == 0) begin : g_c0
      a_r9_legacy0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legacy_i |-> (route_o == 5'd0));
    end else if (CHAN_IDX == 1) begin : g_c1
      a_r9_legacy1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legacy_i |-> (route_o == 5'd8));
    end else begin : g_cn
      a_r9_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
        route_o == cfg_q[RT_LO +: RT_W]);
    end
  endgenerate
endmodule

bind evt_chan evt_chan_chk #(.CHAN_IDX(CHAN_IDX), .CW(CW), .ROUTE_CAP(ROUTE_CAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .glb_en_i(glb_en_i),
  .legacy_i(legacy_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .route_o(route_o),
  .cfg_q(cfg_w), .cmp_q(cmp_w)
);

// File: tb/evt_chan_bench.sv
module evt_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [63:0] count = '0;
  logic        glb_en = 1'b0;
  logic        legacy = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data, rd_data2;
  logic        irq, irq2;
  logic [4:0]  route, route2;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_cfg;
  logic [63:0] m_cmp, m_per;

  always #10 clk = ~clk;

  evt_chan #(.CHAN_IDX(1)) u_evt_chan (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .count_i(count),
    .glb_en_i(glb_en), .legacy_i(legacy), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data), .irq_o(irq), .route_o(route)
  );

  evt_chan #(.CHAN_IDX(2)) u_evt_chan_c2 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .count_i(count),
    .glb_en_i(glb_en), .legacy_i(legacy), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data2), .irq_o(irq2), .route_o(route2)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] trunc(input logic [63:0] v, input logic m32);
    return m32 ? {32'h0, v[31:0]} : v;
  endfunction

  // reference model driven by the requirement text (R2, R4, R5)
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [63:0] t;
    logic ld;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) begin
      m_cfg = (d & 32'h3F4E) | (m_cfg & ~32'h3F4E);
      if (d[8]) begin
        m_cmp = trunc(m_cmp, 1'b1);
        m_per = trunc(m_per, 1'b1);
      end
    end else if (a[1]) begin
      ld = !m_cfg[3] || m_cfg[6];
      t = ld ? m_cmp : m_per;
      if (a == 2'd3) t[63:32] = d; else t[31:0] = d;
      t = trunc(t, m_cfg[8]);
      if (ld) m_cmp = t; else m_per = t;
      m_cfg[6] = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  // R6, R7, R8: drive one tick and check pulse and its one-cycle width
  task automatic tk(input string tag, input logic [63:0] c);
    logic hit;
    hit = glb_en && (m_cfg[8] ? (c[31:0] == m_cmp[31:0]) : (c == m_cmp));
    @(negedge clk);
    count = c; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk({tag, " pulse"}, 64'(irq), 64'(hit && m_cfg[2]));
    if (hit && m_cfg[3]) m_cmp = trunc(m_cmp + m_per, m_cfg[8]);
    @(negedge clk);
    chk({tag, " R6 width"}, 64'(irq), 64'd0);
  endtask

  task automatic chk_cmp(input string tag);
    logic [31:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    chk(tag, {hi, lo}, m_cmp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_cfg = 32'h30; m_cmp = '1; m_per = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R1 cfg reset", 64'(v), 64'h30);
    chk_cmp("R1 cmp reset");
    chk("R1 irq reset", 64'(irq), 64'd0);
    rd(2'd1, v); chk("R3 cap", 64'(v), 64'hFF);

    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); chk("R3 cap after write", 64'(v), 64'hFF);

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 cfg all ones", 64'(v), 64'h3F7E);
    chk_cmp("R5 truncate on mode set");
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R2 cfg cleared", 64'(v), 64'h30);

    wr(2'd0, 32'h0A00);
    #1 chk("R9 field ch1", 64'(route), 64'd5);
    legacy = 1'b1;
    #1 chk("R9 legacy ch1", 64'(route), 64'd8);
    chk("R9 legacy ch2 field", 64'(route2), 64'd5);
    legacy = 1'b0;

    // one-shot
    wr(2'd0, 32'h4);
    wr(2'd2, 32'd100);
    wr(2'd3, 32'd0);
    chk_cmp("R4 one-shot load");
    glb_en = 1'b1;
    tk("R6 miss", 64'd99);
    tk("R6 hit", 64'd100);
    glb_en = 1'b0;
    tk("R8 global off", 64'd100);
    glb_en = 1'b1;
    wr(2'd0, 32'h0);
    tk("R8 channel off", 64'd100);

    // periodic
    wr(2'd0, 32'h4C);
    wr(2'd2, 32'd200);
    rd(2'd0, v); chk("R4 setval cleared", 64'(v), 64'h3C);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd50);
    chk_cmp("R4 period write keeps cmp");
    tk("R7 first", 64'd200);
    chk_cmp("R7 advance 250");
    tk("R7 second", 64'd250);
    chk_cmp("R7 advance 300");
    wr(2'd0, 32'h8);
    tk("R8 periodic chan off", 64'd300);
    chk_cmp("R7 advance without enable");

    // 32-bit mode
    wr(2'd0, 32'h48);
    wr(2'd3, 32'd5);
    chk_cmp("R4 setval high half");
    wr(2'd0, 32'h104);
    chk_cmp("R5 mode set clears high");
    wr(2'd3, 32'd9);
    chk_cmp("R5 high write ignored");
    tk("R6 32-bit compare", 64'h7_0000_015E);

    // random register traffic
    glb_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom % 4);
      d = $urandom;
      wr(a, d);
      rd(2'd0, v); chk("R2 random cfg", 64'(v), 64'(m_cfg));
      chk_cmp("R4 random cmp");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule